// File: doc/BRIEF.md
# Elastic Buffer Self-Check Comparator

This block checks, on demand, that a rate-conversion elastic buffer hands back the same bit that was written into it. When a load strobe arrives while the block is idle, it records the write address presented in that cycle and the data bit being written there. It then follows the read address counter of the buffer. When the read side reaches the recorded address, a fixed three-stage delay lets the buffer's read data settle. The bit on the read data input in the last delay cycle is then compared with the recorded bit.

A difference sets an error flag. The flag stays set until a synchronous clear input removes it. A fill-size inhibit input suppresses the compare when the buffer runs with a very large fill setting. The visible error output is forced low while a timing-activity input reports that no clock activity is present on the incoming line. The buffer memory and its fill and stuff logic lie outside the block.

The controller has three states. IDLE accepts a load: the transition IDLE→WATCH happens on `ld_req`. WATCH waits for address equality: the transition WATCH→SETTLE happens when `rd_addr` equals the recorded address. SETTLE waits out the delay line and performs the compare in its final cycle: the transition SETTLE→IDLE happens when the delayed match leaves the delay line.

Top module: `ebc_selfcheck`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to IDLE with the error flag clear, so `cmp_err` reads 0 after reset.
- R2: A high `ld_req` in IDLE records `wr_addr` and `wr_bit` from that same cycle, and the block moves to WATCH.
- R3: Arming needs all 10 bits of `rd_addr` to equal the recorded address, and only in WATCH. An equal `rd_addr` in the load cycle itself does not arm the block, and neither does an address that differs in a single bit.
- R4: The compare uses `rd_bit` exactly 3 cycles after the arming cycle. A mismatch shows on `cmp_err` one cycle later, which is 4 cycles after arming. `rd_bit` values in other cycles have no effect.
- R5: When the compared bits are equal, no error is raised.
- R6: Once set, the error flag stays at 1 through any later activity, including further loads and clean compares, until it is cleared.
- R7: `clr_err` high at an edge clears the flag. When a mismatch compare and `clr_err` fall in the same cycle, the clear wins and the flag is 0 afterwards.
- R8: A high `fill_inhibit` in the compare cycle suppresses the error. The level of `fill_inhibit` in other cycles has no effect.
- R9: `cmp_err` is the flag ANDed with `clk_activity`, with no delay. When the activity input goes low and then high again, the flag value is unchanged.
- R10: A `ld_req` in WATCH or in SETTLE (including the compare cycle) is ignored. The recorded address and bit keep their values, and a load is accepted again from the cycle after the compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all registers |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_err | input | 1 | Synchronous clear of the error flag |
| ld_req | input | 1 | Sampling strobe: records address and bit |
| wr_addr | input | 10 | Buffer write address |
| wr_bit | input | 1 | Data bit written at `wr_addr` |
| rd_addr | input | 10 | Buffer read address counter |
| rd_bit | input | 1 | Data bit read from the buffer |
| fill_inhibit | input | 1 | Suppresses the compare for large fill settings |
| clk_activity | input | 1 | High while timing activity is present |
| cmp_err | output | 1 | Masked sticky compare error |

## Verification
Two functions can fall in the same cycle: a mismatching compare that would set the flag, and a clear request. The bench places `clr_err` exactly in the SETTLE cycle whose `rd_bit` differs from the recorded bit. It then expects `cmp_err` to read 0 on the next cycle. A second case puts a new load strobe in that same compare cycle. A later mismatching pass over the strobed address must then raise nothing.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WATCH  = 2'd1,
        ST_SETTLE = 2'd2
    } ebc_state_e;

endpackage

// File: rtl/ebc_capture.sv
module ebc_capture #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] addr_in,
    input  logic          bit_in,
    output logic [AW-1:0] addr_q,
    output logic          bit_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            bit_q  <= 1'b0;
        end else if (en) begin
            addr_q <= addr_in;
            bit_q  <= bit_in;
        end
    end

endmodule

// File: rtl/ebc_delay_line.sv
module ebc_delay_line #(
    parameter int N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [N-1:0] sr;

    generate
        if (N == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '0;
                else        sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[N-2:0], d};
            end
        end
    endgenerate

    assign q = sr[N-1];

endmodule

// File: rtl/ebc_err_jk.sv
module ebc_err_jk (
    input  logic clk,
    input  logic rst_n,
    input  logic set_j,
    input  logic clr_k,
    output logic q
);

    // Clear takes precedence over set when both arrive together.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (clr_k) q <= 1'b0;
        else if (set_j) q <= 1'b1;
    end

endmodule

// File: rtl/ebc_selfcheck.sv
module ebc_selfcheck
    import ebc_pkg::*;
#(
    parameter int AW     = 10,
    parameter int STAGES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_err,
    input  logic          ld_req,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_bit,
    input  logic          fill_inhibit,
    input  logic          clk_activity,
    output logic          cmp_err
);

    localparam int ADDR_MSB = AW - 1;

    ebc_state_e        st_q, st_d;
    logic [ADDR_MSB:0] cap_addr;
    logic              cap_bit;
    logic              cap_en;
    logic              addr_eq;
    logic              pipe_in;
    logic              pipe_out;
    logic              cmp_fire;
    logic              err_q;

    assign addr_eq = (rd_addr == cap_addr);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (ld_req)   st_d = ST_WATCH;
            ST_WATCH:  if (addr_eq)  st_d = ST_SETTLE;
            ST_SETTLE: if (pipe_out) st_d = ST_IDLE;
            default:                 st_d = ST_IDLE;
        endcase
    end

    // Per-state outputs
    always_comb begin
        cap_en   = 1'b0;
        pipe_in  = 1'b0;
        cmp_fire = 1'b0;
        unique case (st_q)
            ST_IDLE:   cap_en   = ld_req;
            ST_WATCH:  pipe_in  = addr_eq;
            ST_SETTLE: cmp_fire = pipe_out & ~fill_inhibit & (cap_bit ^ rd_bit);
            default: ;
        endcase
    end

    ebc_capture #(.AW(AW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cap_en),
        .addr_in (wr_addr),
        .bit_in  (wr_bit),
        .addr_q  (cap_addr),
        .bit_q   (cap_bit)
    );

    ebc_delay_line #(.N(STAGES)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pipe_in),
        .q     (pipe_out)
    );

    ebc_err_jk u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_j (cmp_fire),
        .clr_k (clr_err),
        .q     (err_q)
    );

    assign cmp_err = err_q & clk_activity;

endmodule

// File: rtl/ebc_selfcheck_chk.sv
module ebc_selfcheck_chk
    import ebc_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_err,
    input  logic          ld_req,
    input  logic          fill_inhibit,
    input  logic          clk_activity,
    input  logic          cmp_err,
    input  logic          err_q,
    input  logic          pipe_out,
    input  ebc_state_e    st_q,
    input  logic [AW-1:0] cap_addr
);

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (st_q == ST_IDLE && !err_q));

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_err) |=> err_q);

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |=> !err_q);

    a_r4_set_at_compare: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> ($past(st_q) == ST_SETTLE && $past(pipe_out)));

    a_r8_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> !$past(fill_inhibit));

    a_r9_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_activity |-> !cmp_err);

    a_r10_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && ld_req) |=> $stable(cap_addr));

endmodule

bind ebc_selfcheck ebc_selfcheck_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_err      (clr_err),
    .ld_req       (ld_req),
    .fill_inhibit (fill_inhibit),
    .clk_activity (clk_activity),
    .cmp_err      (cmp_err),
    .err_q        (err_q),
    .pipe_out     (pipe_out),
    .st_q         (st_q),
    .cap_addr     (cap_addr)
);

// File: tb/tb_ebc_selfcheck.sv
`timescale 1ns/1ps
module tb_ebc_selfcheck;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr, ld, wb, rb, bf, tok;
    logic [9:0] wa, ra;
    logic       cmp_err;

    int total = 0;
    int bad   = 0;
    string cur_req = "R1";

    // reference model state
    int         m_st  = 0;   // 0 idle, 1 watch, 2 settle
    int         m_cnt = 0;
    logic [9:0] m_a   = '0;
    logic       m_b   = 1'b0;
    logic       m_err = 1'b0;

    always #2.5 clk = ~clk;

    ebc_selfcheck dut (
        .clk(clk), .rst_n(rst_n), .clr_err(clr), .ld_req(ld),
        .wr_addr(wa), .wr_bit(wb), .rd_addr(ra), .rd_bit(rb),
        .fill_inhibit(bf), .clk_activity(tok), .cmp_err(cmp_err)
    );

    task automatic check(input bit cond, input string req, input logic act, input logic exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_adv();
        logic fire;
        fire = 1'b0;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_a = '0; m_b = 1'b0; m_err = 1'b0;
        end else begin
            if (m_st == 0) begin
                if (ld) begin m_a = wa; m_b = wb; m_st = 1; end
            end else if (m_st == 1) begin
                if (ra == m_a) begin m_st = 2; m_cnt = 2; end
            end else begin
                if (m_cnt == 0) begin
                    fire = (rb != m_b) && !bf;
                    m_st = 0;
                end else m_cnt--;
            end
            if (clr)       m_err = 1'b0;
            else if (fire) m_err = 1'b1;
        end
    endtask

    task automatic tick();
        logic exp;
        model_adv();
        @(posedge clk);
        @(negedge clk);
        exp = m_err & tok;
        check(cmp_err === exp, cur_req, cmp_err, exp);
    endtask

    task automatic quiet();
        ld = 0; clr = 0;
    endtask

    task automatic do_load(input logic [9:0] a, input logic b);
        ld = 1; wa = a; wb = b; tick(); ld = 0;
    endtask

    // match cycle then three delay cycles; rd_bit b3 in compare cycle
    task automatic run_compare(input logic [9:0] a, input logic b0, input logic b3);
        ra = a; rb = b0; tick();
        ra = 10'h3FF ^ a; tick();
        tick();
        rb = b3; tick();
        rb = 1'b0; ra = 10'h000;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R1 watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clr = 0; ld = 0; wb = 0; rb = 0; bf = 0; tok = 1; wa = '0; ra = 10'h3FF;
        @(negedge clk);
        // R1: reset
        cur_req = "R1";
        rst_n = 0; tick(); tick();
        check(cmp_err === 1'b0, "R1", cmp_err, 1'b0);
        rst_n = 1; tick();

        // R2 R3 R5: capture, full-width equality, clean compare
        cur_req = "R3";
        ra = 10'h155;
        do_load(10'h155, 1'b1);          // equal in load cycle must not arm
        rb = 1'b0; ra = 10'h154; tick(); // differs in bit 0
        ra = 10'h355; tick();            // differs in bit 9
        tick(); tick(); tick();
        check(cmp_err === 1'b0, "R3", cmp_err, 1'b0);
        cur_req = "R5";
        run_compare(10'h155, 1'b1, 1'b1);
        tick();
        check(cmp_err === 1'b0, "R5", cmp_err, 1'b0);

        // R4: only the compare cycle rd_bit counts
        cur_req = "R4";
        do_load(10'h0A3, 1'b0);
        ra = 10'h0A3; rb = 1'b1; tick();
        ra = 10'h000; tick();
        tick();
        rb = 1'b0; tick();
        check(cmp_err === 1'b0, "R4", cmp_err, 1'b0);
        do_load(10'h0A3, 1'b0);
        ra = 10'h0A3; rb = 1'b0; tick();
        ra = 10'h000; tick();
        check(cmp_err === 1'b0, "R4", cmp_err, 1'b0);
        tick();
        check(cmp_err === 1'b0, "R4", cmp_err, 1'b0);
        rb = 1'b1; tick();
        check(cmp_err === 1'b1, "R4", cmp_err, 1'b1);
        rb = 1'b0;

        // R6: sticky through later clean activity
        cur_req = "R6";
        tick(); tick();
        do_load(10'h2F0, 1'b1);
        run_compare(10'h2F0, 1'b1, 1'b1);
        tick();
        check(cmp_err === 1'b1, "R6", cmp_err, 1'b1);

        // R9: activity mask
        cur_req = "R9";
        tok = 0; tick();
        check(cmp_err === 1'b0, "R9", cmp_err, 1'b0);
        tok = 1; tick();
        check(cmp_err === 1'b1, "R9", cmp_err, 1'b1);

        // R7: clear, then clear coinciding with mismatch
        cur_req = "R7";
        clr = 1; tick(); clr = 0;
        check(cmp_err === 1'b0, "R7", cmp_err, 1'b0);
        do_load(10'h011, 1'b1);
        ra = 10'h011; rb = 1'b0; tick();
        ra = 10'h000; tick(); tick();
        clr = 1; tick(); clr = 0;
        check(cmp_err === 1'b0, "R7", cmp_err, 1'b0);

        // R8: inhibit only matters in compare cycle
        cur_req = "R8";
        do_load(10'h1C7, 1'b1);
        ra = 10'h1C7; rb = 1'b0; tick();
        ra = 10'h000; tick(); tick();
        bf = 1; tick(); bf = 0;
        check(cmp_err === 1'b0, "R8", cmp_err, 1'b0);
        do_load(10'h1C7, 1'b1);
        bf = 1; ra = 10'h1C7; rb = 1'b0; tick();
        ra = 10'h000; tick(); tick();
        bf = 0; tick();
        check(cmp_err === 1'b1, "R8", cmp_err, 1'b1);
        clr = 1; tick(); clr = 0;

        // R10: loads while pending are ignored
        cur_req = "R10";
        do_load(10'h0F0, 1'b0);
        do_load(10'h00F, 1'b1);          // ignored
        ra = 10'h00F; rb = 1'b1; tick(); tick(); tick(); tick();
        check(cmp_err === 1'b0, "R10", cmp_err, 1'b0);
        ra = 10'h0F0; rb = 1'b1; tick();
        ra = 10'h000; tick(); tick();
        ld = 1; wa = 10'h333; wb = 1'b1; tick(); ld = 0;   // compare cycle, load ignored
        check(cmp_err === 1'b1, "R10", cmp_err, 1'b1);
        clr = 1; tick(); clr = 0;
        // next mismatch on 0x333 must not happen: block is idle, no arming
        run_compare(10'h333, 1'b0, 1'b0);
        tick();
        check(cmp_err === 1'b0, "R10", cmp_err, 1'b0);
        // a load is accepted again
        do_load(10'h333, 1'b1);
        run_compare(10'h333, 1'b0, 1'b0);
        check(cmp_err === 1'b1, "R2", cmp_err, 1'b1);

        quiet(); tick();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule